// File: doc/BRIEF.md
# Serial Ones Counter with Nibble Loader

This block counts how many bits are set in a 16-bit value that is entered four bits at a time. A 4-bit register first takes a group in parallel. It then moves that group bit by bit toward its low end. On each move the bit that leaves the register is added to a stored 4-bit total. A one-cycle step strobe, which stands in for a button press, times every update. A mode input picks what each step does: a load or a shift.

In normal use the 16-bit value is four decimal digits, each held in a 4-bit group. The least significant digit is entered first. Each digit takes one load step and then four shift steps. After those twenty steps the total on the count output equals the number of ones in the whole value. No digit from 0 to 9 holds more than three ones, so the total never goes past 12.

Top module: `serial_ones_counter`

## Requirements
- R1: A high `rst` at a rising clock edge clears both the shift register and the count to 0 in that cycle. This holds even when `step` is high.
- R2: A step with `mode` = 0 (load) copies `par_in` into the shift register. The count does not change.
- R3: A step with `mode` = 1 (shift) moves the register one bit toward bit 0 and writes 0 into bit 3. `ser_bit` always shows bit 0 of the register.
- R4: A step with `mode` = 1 adds the `ser_bit` value from before the step to the count. The sum is taken modulo 16.
- R5: In a cycle with `step` low, the register and the count keep their values, whatever `mode` and `par_in` are.
- R6: After one load and four shifts per digit, applied to four decimal digits with the lowest digit first, the count equals the number of ones in the 16-bit value. For a loaded 0110 the count goes 0, 1, 2, 2 over the four shifts.
- R7: Four shift steps after a load leave the shift register at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| step | input | 1 | One-cycle strobe that enables an update |
| mode | input | 1 | 0 = parallel load, 1 = shift and accumulate |
| par_in | input | 4 | Parallel group for a load step |
| count | output | 4 | Running count of ones |
| ser_bit | output | 1 | Bit 0 of the shift register, the next bit to be added |
| shreg | output | 4 | Shift register contents, for debug |

## Verification
The assertions check every step rule on every cycle: load copying, shifting with zero fill, adding the outgoing bit, leaving the count alone on loads, holding when idle, and reset priority. Only the bench scenarios can show the results that depend on a whole sequence. These are the twenty-step total for digit sets such as 0000, 9999, 7777 and random digits, the 0, 1, 2, 2 progression for 0110, and the register being empty after four shifts.

// File: rtl/ones_cnt_pkg.sv
package ones_cnt_pkg;
    typedef enum logic {
        MODE_LOAD  = 1'b0,
        MODE_SHIFT = 1'b1
    } step_mode_e;
endpackage

// File: rtl/nibble_loader.sv
module nibble_loader
    import ones_cnt_pkg::*;
#(
    parameter int GRP_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    input  logic             mode,
    input  logic [GRP_W-1:0] par_in,
    output logic [GRP_W-1:0] bits,
    output logic             out_bit
);
    typedef struct packed {
        logic [GRP_W-1:0] sh;
    } ld_state_t;

    ld_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (step) begin
            if (step_mode_e'(mode) == MODE_LOAD) begin
                st_d.sh = par_in;
            end else begin
                st_d.sh = {1'b0, st_q.sh[GRP_W-1:1]};
            end
        end
        if (rst) begin
            st_d.sh = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign bits    = st_q.sh;
    assign out_bit = st_q.sh[0];

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (bits == '0));
    assert_load_copy_R2: assert property (@(posedge clk) disable iff (rst)
        (step && !mode) |=> (bits == $past(par_in)));
    assert_shift_fill_R3: assert property (@(posedge clk) disable iff (rst)
        (step && mode) |=> (bits == ($past(bits) >> 1)));
    assert_idle_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(bits));
endmodule

// File: rtl/ones_accum.sv
module ones_accum #(
    parameter int SUM_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             add_en,
    input  logic             bit_in,
    output logic [SUM_W-1:0] sum
);
    typedef struct packed {
        logic [SUM_W-1:0] acc;
    } acc_state_t;

    acc_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (add_en) begin
            st_d.acc = st_q.acc + SUM_W'(bit_in);
        end
        if (rst) begin
            st_d.acc = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign sum = st_q.acc;

    assert_sum_clear_R1: assert property (@(posedge clk)
        rst |=> (sum == '0));
    assert_add_bit_R4: assert property (@(posedge clk) disable iff (rst)
        add_en |=> (sum == $past(sum) + SUM_W'($past(bit_in))));
    assert_sum_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !add_en |=> $stable(sum));
endmodule

// File: rtl/serial_ones_counter.sv
module serial_ones_counter
    import ones_cnt_pkg::*;
#(
    parameter int GRP_W = 4,
    parameter int SUM_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    input  logic             mode,
    input  logic [GRP_W-1:0] par_in,
    output logic [SUM_W-1:0] count,
    output logic             ser_bit,
    output logic [GRP_W-1:0] shreg
);
    logic add_en;

    assign add_en = step && (step_mode_e'(mode) == MODE_SHIFT);

    nibble_loader #(.GRP_W(GRP_W)) u_loader (
        .clk     (clk),
        .rst     (rst),
        .step    (step),
        .mode    (mode),
        .par_in  (par_in),
        .bits    (shreg),
        .out_bit (ser_bit)
    );

    ones_accum #(.SUM_W(SUM_W)) u_accum (
        .clk    (clk),
        .rst    (rst),
        .add_en (add_en),
        .bit_in (ser_bit),
        .sum    (count)
    );

    assert_load_keeps_count_R2: assert property (@(posedge clk) disable iff (rst)
        (step && !mode) |=> $stable(count));
    assert_serial_tap_R3: assert property (@(posedge clk)
        ser_bit == shreg[0]);
endmodule

// File: tb/test_serial_ones_counter.sv
module test_serial_ones_counter;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       step = 1'b0;
    logic       mode = 1'b0;
    logic [3:0] par_in = 4'd0;
    logic [3:0] count;
    logic       ser_bit;
    logic [3:0] shreg;

    int checks = 0;
    int errors = 0;
    logic [3:0] m_sh  = 4'd0;
    logic [3:0] m_cnt = 4'd0;

    always #5 clk = ~clk;

    serial_ones_counter i_serial_ones_counter (
        .clk(clk), .rst(rst), .step(step), .mode(mode), .par_in(par_in),
        .count(count), .ser_bit(ser_bit), .shreg(shreg)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int ref_ones(input logic [15:0] v);
        int n = 0;
        for (int i = 0; i < 16; i++) n += int'(v[i]);
        return n;
    endfunction

    task automatic check_state(input string req);
        chk({req, " shreg"}, int'(shreg), int'(m_sh));
        chk({req, " count"}, int'(count), int'(m_cnt));
        chk({"R3 ser_bit"}, int'(ser_bit), int'(m_sh[0]));
    endtask

    task automatic do_step(input logic md, input logic [3:0] d, input string req);
        @(negedge clk);
        mode = md; par_in = d; step = 1'b1;
        @(posedge clk);
        @(negedge clk);
        step = 1'b0;
        par_in = 4'($urandom);
        if (md == 1'b0) begin
            m_sh = d;
        end else begin
            m_cnt = m_cnt + {3'd0, m_sh[0]};
            m_sh = m_sh >> 1;
        end
        check_state(req);
    endtask

    task automatic do_reset(input logic with_step);
        @(negedge clk);
        rst = 1'b1; step = with_step; mode = 1'b0; par_in = 4'hF;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0; step = 1'b0;
        m_sh = 0; m_cnt = 0;
        check_state("R1");
    endtask

    task automatic run_digits(input logic [15:0] v);
        for (int g = 0; g < 4; g++) begin
            do_step(1'b0, v[4*g +: 4], "R2");
            for (int s = 0; s < 4; s++) do_step(1'b1, 4'($urandom), "R4");
            chk("R7 empty after shifts", int'(shreg), 0);
        end
        chk("R6 total ones", int'(count), ref_ones(v));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_sh = 0; m_cnt = 0;
        check_state("R1 reset state");

        // R6: digit 0110 progression 0,1,2,2
        begin
            int exp_seq[4] = '{0, 1, 2, 2};
            do_step(1'b0, 4'b0110, "R2");
            for (int s = 0; s < 4; s++) begin
                do_step(1'b1, 4'd0, "R4");
                chk("R6 0110 progression", int'(count), exp_seq[s]);
            end
        end

        do_reset(1'b0); run_digits(16'h0000);
        do_reset(1'b0); run_digits(16'h9999);
        do_reset(1'b0); run_digits(16'h7777);
        do_reset(1'b0); run_digits(16'h1234);

        // R5: idle cycles with toggling inputs
        do_step(1'b0, 4'b1011, "R2");
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            mode = 1'($urandom); par_in = 4'($urandom);
            @(posedge clk);
            @(negedge clk);
            check_state("R5 idle hold");
        end

        // R1: reset wins over a step strobe
        do_reset(1'b1);

        // random BCD digit sets
        for (int t = 0; t < 20; t++) begin
            logic [15:0] v;
            for (int g = 0; g < 4; g++) v[4*g +: 4] = 4'($urandom_range(0, 9));
            do_reset(1'b0);
            run_digits(v);
        end

        // random mode mix including wrap modulo 16
        for (int t = 0; t < 300; t++) begin
            do_step(1'($urandom), 4'($urandom), "R4 mixed");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule